// File: doc/BRIEF.md
# SPI Burst Transfer Sequencer

This block is the data path of an 8-bit SPI master. Software (through a register decoder that lives elsewhere) fills a 64-byte transmit queue, programs a total frame count and a smaller data count, and pulses a start input. The sequencer then clocks out one burst of byte frames. The first frames take their bytes from the transmit queue. Once the data count is used up, the remaining frames send the filler byte 0x00. Each byte received on the serial input goes into a 64-byte receive queue, unless the discard control is set for a transmit-only burst.

The serial clock advances only on cycles where an external divider asserts a tick input, so the divider sets the bit rate. Clock polarity, clock phase and bit order are independent controls with the usual SPI meaning. When the last frame ends, a sticky completion flag is set. The flag drives the interrupt output when the interrupt enable is high, and a clear strobe resets it.

Both queues use valid/ready handshakes at the block's edge. A producer may hold `tx_valid` high with stable `tx_data`, and a byte is taken on any cycle where `tx_ready` is also high. `tx_ready` is low only while the transmit queue holds 64 bytes. The receive side presents the oldest byte on `rx_data` while `rx_valid` is high, and that byte is consumed on a cycle where `rx_ready` is high. Inside the block the sequencer never waits on the receive queue: a byte that arrives while the receive queue is full is lost.

Top module: `spi_burst_seq`

## Requirements
- R1: Each queue holds up to 64 bytes and reports its occupancy from 0 to 64 on a 7-bit level output. `tx_ready` is low only when the transmit level is 64, and a push offered while the queue is full is not stored. Bytes leave each queue in arrival order.
- R2: A start pulse while idle latches the 24-bit total count and the 24-bit data count, then clocks exactly that many 8-bit frames, with `busy` high throughout. A total count of 0 completes without any serial clock edge.
- R3: A frame whose zero-based index is below the latched data count sends a byte popped from the transmit queue. All later frames send 0x00 and pop nothing, so bytes beyond the data count stay queued.
- R4: While idle, `sclk` rests at `cfg_cpol`. With `cfg_cpha`=0 the first bit is on `mosi` before the first clock edge, `miso` is sampled on leading edges and `mosi` changes on trailing edges. With `cfg_cpha`=1 `mosi` changes on leading edges and `miso` is sampled on trailing edges. A frame has 8 serial clock periods, and `sclk` changes only after a cycle with `sclk_tick` high.
- R5: With `cfg_lsb_first`=1, bit 0 is sent and received first. With `cfg_lsb_first`=0, bit 7 comes first. The control applies to both directions.
- R6: Each received frame is pushed into the receive queue unless `cfg_discard_rx` is 1. A frame that arrives while the receive queue is full is dropped.
- R7: If a data frame finds the transmit queue empty, the sequencer waits with `sclk` at its idle level and makes no edges until a byte arrives, then continues the burst.
- R8: `done_flag` is set when a burst completes and stays set until a `done_clr` pulse. `irq` is high only when both `done_flag` and `irq_en` are high.
- R9: A start pulse while `busy` is high has no effect: the current burst ends after its programmed count and no second burst follows.
- R10: `tx_fifo_clr` and `rx_fifo_clr` empty their queue on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_tick | input | 1 | Half-period advance enable from the external divider |
| cfg_cpol | input | 1 | Idle level of sclk |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | Bit order, 1 = bit 0 first |
| cfg_discard_rx | input | 1 | Do not store received frames |
| burst_len | input | 24 | Total frames in a burst |
| tx_len | input | 24 | Frames that take data from the transmit queue |
| start | input | 1 | Start pulse, taken only while idle |
| tx_fifo_clr | input | 1 | Empty the transmit queue |
| rx_fifo_clr | input | 1 | Empty the receive queue |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit queue can accept |
| rx_valid | output | 1 | Receive byte available |
| rx_data | output | 8 | Oldest received byte |
| rx_ready | input | 1 | Consume the receive byte |
| tx_level | output | 7 | Transmit queue occupancy |
| rx_level | output | 7 | Receive queue occupancy |
| busy | output | 1 | Burst in progress |
| irq_en | input | 1 | Completion interrupt enable |
| done_clr | input | 1 | Clear the completion flag |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Completion interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest case to reach is a stall in the middle of a burst: the sequencer has to run out of transmit data partway through, with the serial clock parked, and then resume. The stimulus gets there by queuing one byte for a three-frame burst with a data count of three. It waits until the bench's serial monitor has seen eight bits, holds the clock for many cycles while checking that `sclk` stays idle and no more bits appear, then pushes the two missing bytes and checks the whole burst. A bench-side slave model with its own bit-order convention checks both directions in all four modes. Because the model is independent of the design, a bit-order fault cannot cancel out the way it would in a loopback.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_LOAD  = 2'd1,
    SEQ_SHIFT = 2'd2,
    SEQ_DONE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/sbs_fifo.sv
module sbs_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  input  logic             out_ready,
  output logic [CW-1:0]    level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             push, pop;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign level     = count;

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/sbs_shift_engine.sv
module sbs_shift_engine
  import spi_burst_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              discard,
  input  logic              start,
  input  logic [CNT_W-1:0]  total_cnt,
  input  logic [CNT_W-1:0]  data_cnt,
  input  logic              src_valid,
  input  logic [BYTE_W-1:0] src_data,
  output logic              src_pop,
  output logic              sink_push,
  output logic [BYTE_W-1:0] sink_data,
  output logic              busy,
  output logic              done_pulse,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int EDGES = 2 * BYTE_W;
  localparam int EW    = $clog2(EDGES);

  seq_state_e        state;
  logic [CNT_W-1:0]  frame_cnt, total_q, data_q;
  logic [EW-1:0]     edge_cnt;
  logic              sclk_int, mosi_q;
  logic [BYTE_W-1:0] tx_sr, rx_sr, rx_next, load_byte;
  logic              need_data, leading, drive_ev, sample_ev, last_edge;

  function automatic logic out_bit(input logic [BYTE_W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[BYTE_W-1];
  endfunction

  function automatic logic [BYTE_W-1:0] shifted(input logic [BYTE_W-1:0] v, input logic lsb);
    return lsb ? {1'b0, v[BYTE_W-1:1]} : {v[BYTE_W-2:0], 1'b0};
  endfunction

  assign need_data = (frame_cnt < data_q);
  assign load_byte = need_data ? src_data : '0;
  assign src_pop   = (state == SEQ_LOAD) && need_data && src_valid;
  assign leading   = !edge_cnt[0];
  assign drive_ev  = cpha ? leading : !leading;
  assign sample_ev = cpha ? !leading : leading;
  assign last_edge = (edge_cnt == EW'(EDGES - 1));
  assign rx_next   = lsb_first ? {miso, rx_sr[BYTE_W-1:1]} : {rx_sr[BYTE_W-2:0], miso};

  // With cpha=1 the final sample lands on the last edge, so forward it directly.
  assign sink_data  = cpha ? rx_next : rx_sr;
  assign sink_push  = (state == SEQ_SHIFT) && tick && last_edge && !discard;
  assign busy       = (state != SEQ_IDLE);
  assign done_pulse = (state == SEQ_DONE);
  assign sclk       = cpol ^ sclk_int;
  assign mosi       = mosi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      frame_cnt <= '0;
      total_q   <= '0;
      data_q    <= '0;
      edge_cnt  <= '0;
      sclk_int  <= 1'b0;
      mosi_q    <= 1'b0;
      tx_sr     <= '0;
      rx_sr     <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          sclk_int <= 1'b0;
          if (start) begin
            total_q   <= total_cnt;
            data_q    <= data_cnt;
            frame_cnt <= '0;
            state     <= (total_cnt == '0) ? SEQ_DONE : SEQ_LOAD;
          end
        end
        SEQ_LOAD: begin
          if (!need_data || src_valid) begin
            edge_cnt <= '0;
            state    <= SEQ_SHIFT;
            if (!cpha) begin
              mosi_q <= out_bit(load_byte, lsb_first);
              tx_sr  <= shifted(load_byte, lsb_first);
            end else begin
              tx_sr  <= load_byte;
            end
          end
        end
        SEQ_SHIFT: begin
          if (tick) begin
            sclk_int <= ~sclk_int;
            edge_cnt <= edge_cnt + 1'b1;
            if (drive_ev) begin
              mosi_q <= out_bit(tx_sr, lsb_first);
              tx_sr  <= shifted(tx_sr, lsb_first);
            end
            if (sample_ev) rx_sr <= rx_next;
            if (last_edge) begin
              frame_cnt <= frame_cnt + 1'b1;
              state     <= (frame_cnt + 1'b1 == total_q) ? SEQ_DONE : SEQ_LOAD;
            end
          end
        end
        SEQ_DONE: state <= SEQ_IDLE;
        default:  state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq
  import spi_burst_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = 24
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            sclk_tick,
  input  logic                            cfg_cpol,
  input  logic                            cfg_cpha,
  input  logic                            cfg_lsb_first,
  input  logic                            cfg_discard_rx,
  input  logic [CNT_W-1:0]                burst_len,
  input  logic [CNT_W-1:0]                tx_len,
  input  logic                            start,
  input  logic                            tx_fifo_clr,
  input  logic                            rx_fifo_clr,
  input  logic                            tx_valid,
  input  logic [BYTE_W-1:0]               tx_data,
  output logic                            tx_ready,
  output logic                            rx_valid,
  output logic [BYTE_W-1:0]               rx_data,
  input  logic                            rx_ready,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] tx_level,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] rx_level,
  output logic                            busy,
  input  logic                            irq_en,
  input  logic                            done_clr,
  output logic                            done_flag,
  output logic                            irq,
  output logic                            sclk,
  output logic                            mosi,
  input  logic                            miso
);
  logic              src_valid, src_pop, sink_push, sink_ready_unused, done_pulse;
  logic [BYTE_W-1:0] src_data, sink_data;

  sbs_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(tx_fifo_clr),
    .in_valid(tx_valid), .in_data(tx_data), .in_ready(tx_ready),
    .out_valid(src_valid), .out_data(src_data), .out_ready(src_pop),
    .level(tx_level)
  );

  sbs_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(rx_fifo_clr),
    .in_valid(sink_push), .in_data(sink_data), .in_ready(sink_ready_unused),
    .out_valid(rx_valid), .out_data(rx_data), .out_ready(rx_ready),
    .level(rx_level)
  );

  sbs_shift_engine #(.CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .tick(sclk_tick),
    .cpol(cfg_cpol), .cpha(cfg_cpha), .lsb_first(cfg_lsb_first),
    .discard(cfg_discard_rx), .start(start),
    .total_cnt(burst_len), .data_cnt(tx_len),
    .src_valid(src_valid), .src_data(src_data), .src_pop(src_pop),
    .sink_push(sink_push), .sink_data(sink_data),
    .busy(busy), .done_pulse(done_pulse),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          done_flag <= 1'b0;
    else if (done_pulse) done_flag <= 1'b1;
    else if (done_clr)   done_flag <= 1'b0;
  end

  assign irq = done_flag && irq_en;
endmodule

// File: rtl/spi_burst_seq_checker.sv
module spi_burst_seq_checker #(
  parameter int LW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sclk_tick,
  input logic          cfg_cpol,
  input logic          cfg_discard_rx,
  input logic          start,
  input logic          rx_ready,
  input logic          tx_ready,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          busy,
  input logic          done_clr,
  input logic          done_flag,
  input logic          sclk
);
  localparam logic [LW-1:0] FULL = LW'(64);

  AST_TX_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n) tx_level <= FULL); // R1
  AST_RX_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n) rx_level <= FULL); // R1
  AST_TX_FULL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == FULL) |-> !tx_ready); // R1
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cfg_cpol)); // R4
  AST_SCLK_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_tick |=> ((sclk ^ cfg_cpol) == $past(sclk ^ cfg_cpol))); // R4
  AST_DISCARD_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_discard_rx && !rx_ready) |=> (rx_level <= $past(rx_level))); // R6
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(busy)); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !done_clr) |=> done_flag); // R8
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done_flag) |=> (busy || $rose(done_flag))); // R9
endmodule

bind spi_burst_seq spi_burst_seq_checker #(.LW($clog2(FIFO_DEPTH+1))) u_checker (
  .clk(clk), .rst_n(rst_n), .sclk_tick(sclk_tick), .cfg_cpol(cfg_cpol),
  .cfg_discard_rx(cfg_discard_rx), .start(start), .rx_ready(rx_ready),
  .tx_ready(tx_ready), .tx_level(tx_level), .rx_level(rx_level), .busy(busy),
  .done_clr(done_clr), .done_flag(done_flag), .sclk(sclk)
);

// File: tb/tb_spi_burst_seq.sv
module tb_spi_burst_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic cfg_cpol = 0, cfg_cpha = 0, cfg_lsb_first = 0, cfg_discard_rx = 0;
  logic [23:0] burst_len = '0, tx_len = '0;
  logic start = 0, tx_fifo_clr = 0, rx_fifo_clr = 0;
  logic tx_valid = 0, rx_ready = 0, irq_en = 0, done_clr = 0;
  logic [7:0] tx_data = '0, rx_data;
  logic tx_ready, rx_valid, busy, done_flag, irq, sclk, mosi, miso;
  logic [6:0] tx_level, rx_level;

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench slave model
  bit   mon_en = 0;
  int   ncap = 0, sp = 0;
  logic cap_bits [0:1023];
  logic [7:0] s_bytes [0:127];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tick <= ~tick;

  spi_burst_seq dut (
    .clk(clk), .rst_n(rst_n), .sclk_tick(tick), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .cfg_discard_rx(cfg_discard_rx),
    .burst_len(burst_len), .tx_len(tx_len), .start(start),
    .tx_fifo_clr(tx_fifo_clr), .rx_fifo_clr(rx_fifo_clr),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_level(tx_level), .rx_level(rx_level), .busy(busy),
    .irq_en(irq_en), .done_clr(done_clr), .done_flag(done_flag), .irq(irq),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  function automatic logic slave_bit(input int p, input logic lsb);
    logic [7:0] b;
    if (p < 0) return 1'b0;
    b = s_bytes[(p / 8) % 128];
    return lsb ? b[p % 8] : b[7 - (p % 8)];
  endfunction

  assign miso = slave_bit(sp, cfg_lsb_first);

  always @(sclk) begin
    if (mon_en) begin
      if (sclk != cfg_cpol) begin
        if (!cfg_cpha) begin cap_bits[ncap % 1024] = mosi; ncap++; end
        else sp++;
      end else begin
        if (cfg_cpha) begin cap_bits[ncap % 1024] = mosi; ncap++; end
        else sp++;
      end
    end
  end

  function automatic logic [7:0] got_byte(input int k);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      if (cfg_lsb_first) b[i] = cap_bits[8*k + i];
      else               b[7-i] = cap_bits[8*k + i];
    end
    return b;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk); tx_valid = 1; tx_data = b;
    @(negedge clk); tx_valid = 0;
  endtask

  task automatic pop_rx(output logic [7:0] b);
    @(negedge clk); b = rx_data; rx_ready = 1;
    @(negedge clk); rx_ready = 0;
  endtask

  task automatic pulse_clr_done();
    @(negedge clk); done_clr = 1;
    @(negedge clk); done_clr = 0;
  endtask

  task automatic kick(input int blen, input int tlen);
    @(negedge clk);
    burst_len = 24'(blen); tx_len = 24'(tlen);
    ncap = 0; sp = cfg_cpha ? -1 : 0; mon_en = 1;
    start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && !done_flag; i++) @(negedge clk);
  endtask

  task automatic run_burst(input int blen, input int tlen);
    kick(blen, tlen);
    wait_done();
    mon_en = 0;
  endtask

  task automatic t_reset();
    check(tx_level == 0 && rx_level == 0, "R1 reset levels", tx_level, 0);
    check(!busy && !done_flag && !irq, "R8 reset flags", {busy, done_flag, irq}, 0);
    check(sclk == cfg_cpol, "R4 reset sclk idle", sclk, cfg_cpol);
  endtask

  // R4 R5: every mode and both bit orders against the slave model
  task automatic t_mode(input bit pol, input bit pha, input bit lsb, input int seed);
    logic [7:0] d [3];
    logic [7:0] r;
    @(negedge clk); cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb; cfg_discard_rx = 0;
    for (int i = 0; i < 3; i++) begin
      d[i] = 8'(8'h1D * (seed + i) + 8'h35);
      s_bytes[i] = 8'(8'hC3 ^ (8'h29 * (seed + i)) ^ 8'h01);
      push_tx(d[i]);
    end
    run_burst(3, 3);
    check(done_flag, "R2 mode burst done", done_flag, 1);
    check(ncap == 24, "R2 R4 mode bit count", ncap, 24);
    @(negedge clk);
    check(sclk == pol, "R4 idle level after burst", sclk, pol);
    for (int i = 0; i < 3; i++) begin
      check(got_byte(i) == d[i], "R5 mosi byte", got_byte(i), d[i]);
      pop_rx(r);
      check(r == s_bytes[i], "R5 R4 miso byte", r, s_bytes[i]);
    end
    pulse_clr_done();
  endtask

  // R3: filler frames and untouched queue contents
  task automatic t_filler();
    @(negedge clk); cfg_cpol = 0; cfg_cpha = 0; cfg_lsb_first = 0;
    push_tx(8'hA5); push_tx(8'h5A); push_tx(8'h77); push_tx(8'h88);
    run_burst(5, 2);
    check(got_byte(0) == 8'hA5 && got_byte(1) == 8'h5A, "R3 data frames", got_byte(1), 8'h5A);
    for (int i = 2; i < 5; i++) check(got_byte(i) == 8'h00, "R3 filler 0x00", got_byte(i), 0);
    check(tx_level == 2, "R3 unused bytes stay queued", tx_level, 2);
    check(rx_level == 5, "R6 rx frames stored", rx_level, 5);
    @(negedge clk); tx_fifo_clr = 1; rx_fifo_clr = 1;
    @(negedge clk); tx_fifo_clr = 0; rx_fifo_clr = 0;
    check(tx_level == 0 && rx_level == 0, "R10 clear strobes", {tx_level, rx_level}, 0);
    pulse_clr_done();
  endtask

  // R6: discard keeps the receive queue empty
  task automatic t_discard();
    @(negedge clk); cfg_discard_rx = 1;
    push_tx(8'h3C);
    run_burst(4, 1);
    check(rx_level == 0, "R6 discard keeps rx empty", rx_level, 0);
    check(got_byte(0) == 8'h3C, "R6 discard still sends", got_byte(0), 8'h3C);
    @(negedge clk); cfg_discard_rx = 0;
    pulse_clr_done();
  endtask

  // R7: stall on empty transmit queue
  task automatic t_stall();
    logic s0;
    @(negedge clk); cfg_cpol = 1; cfg_cpha = 1; cfg_lsb_first = 0;
    push_tx(8'hE1);
    kick(3, 3);
    for (int i = 0; i < 5000 && ncap < 8; i++) @(negedge clk);
    repeat (60) @(negedge clk);
    s0 = sclk;
    check(busy, "R7 still busy while stalled", busy, 1);
    check(ncap == 8, "R7 no edges while stalled", ncap, 8);
    check(s0 == 1'b1, "R7 sclk parked idle", s0, 1);
    push_tx(8'h42); push_tx(8'h99);
    wait_done(); mon_en = 0;
    check(done_flag && ncap == 24, "R7 resumes to completion", ncap, 24);
    check(got_byte(1) == 8'h42 && got_byte(2) == 8'h99, "R7 resumed data", got_byte(2), 8'h99);
    @(negedge clk); rx_fifo_clr = 1; @(negedge clk); rx_fifo_clr = 0;
    pulse_clr_done();
  endtask

  // R8: interrupt gating and sticky flag
  task automatic t_irq();
    @(negedge clk); cfg_cpol = 0; cfg_cpha = 0; irq_en = 0; cfg_discard_rx = 1;
    run_burst(1, 0);
    check(done_flag && !irq, "R8 irq gated off", irq, 0);
    @(negedge clk); irq_en = 1;
    @(negedge clk);
    check(irq, "R8 irq follows enable", irq, 1);
    repeat (20) @(negedge clk);
    check(done_flag, "R8 flag sticky", done_flag, 1);
    pulse_clr_done();
    check(!done_flag && !irq, "R8 clear", {done_flag, irq}, 0);
    irq_en = 0; cfg_discard_rx = 0;
  endtask

  // R9: restart while busy ignored
  task automatic t_restart();
    @(negedge clk); cfg_discard_rx = 1;
    kick(2, 0);
    repeat (6) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    wait_done();
    pulse_clr_done();
    repeat (80) @(negedge clk);
    mon_en = 0;
    check(!busy && !done_flag, "R9 no second burst", {busy, done_flag}, 0);
    check(ncap == 16, "R9 bits of one burst only", ncap, 16);
    cfg_discard_rx = 0;
  endtask

  // R2: zero-length burst
  task automatic t_zero();
    run_burst(0, 0);
    check(done_flag, "R2 zero burst completes", done_flag, 1);
    check(ncap == 0, "R2 zero burst has no edges", ncap, 0);
    pulse_clr_done();
  endtask

  // R1: transmit queue full behaviour and order
  task automatic t_tx_full();
    logic rdy;
    for (int i = 0; i < 64; i++) push_tx(8'(i));
    check(tx_level == 64, "R1 tx full level", tx_level, 64);
    rdy = tx_ready;
    check(!rdy, "R1 tx_ready low when full", rdy, 0);
    push_tx(8'hFF);
    check(tx_level == 64, "R1 push into full dropped", tx_level, 64);
    @(negedge clk); cfg_discard_rx = 1;
    run_burst(2, 2);
    check(got_byte(0) == 8'h00 && got_byte(1) == 8'h01, "R1 tx order", got_byte(1), 1);
    pulse_clr_done();
    @(negedge clk); tx_fifo_clr = 1; @(negedge clk); tx_fifo_clr = 0; cfg_discard_rx = 0;
  endtask

  // R6 R1: receive queue overflow drops late frames
  task automatic t_rx_full();
    logic [7:0] r;
    for (int i = 0; i < 70; i++) s_bytes[i] = 8'(i * 3 + 1);
    run_burst(70, 0);
    check(rx_level == 64, "R6 rx full drops extra frames", rx_level, 64);
    for (int i = 0; i < 2; i++) begin
      pop_rx(r);
      check(r == s_bytes[i], "R1 rx order", r, s_bytes[i]);
    end
    @(negedge clk); rx_fifo_clr = 1; @(negedge clk); rx_fifo_clr = 0;
    pulse_clr_done();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    for (int m = 0; m < 8; m++) t_mode(m[1], m[0], m[2], m * 5 + 2);
    t_filler();
    t_discard();
    t_stall();
    t_irq();
    t_restart();
    t_zero();
    t_tx_full();
    t_rx_full();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule